// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block models the control logic of a three-wire serial EEPROM. The host raises a chip select and shifts commands in on a serial data line, one bit per rising edge of a serial clock. The block returns read data and ready/busy status on a serial output with a separate output enable; a low enable stands for high impedance. A command is a start bit, a two-bit opcode and an address. Reads can run on through consecutive locations. The programming commands are single-location write, single-location erase, erase-everything and write-everything. Each of these runs as a self-timed cycle counted in system clocks.

The array is an internal byte memory. An organisation input selects whether it is addressed as 16-bit words or as bytes. A write-enable latch guards every programming command. `sk` is sampled in the `clk` domain, and the block acts on each rising edge it detects there. Cycle lengths are parameters: `T_WORD` for a single location, `T_ERAL` for erase-all and `T_WRAL` for write-all. Write-all runs its own erase-all phase before it writes.

Top module: `mw_eeprom_ctl`

## Requirements
- R1: Bits are taken from `di` on each detected rising edge of `sk` while `cs` is high. Zeros before the first 1 are skipped, and that 1 is the start bit. It is followed by a 2-bit opcode, MSB first, and then an address, MSB first. The address is `AW16` bits when `org_x16`=1 and `AW16`+1 bits when `org_x16`=0. Opcodes: 10 read, 01 write, 11 erase, 00 extended. An extended command takes its meaning from the two top address bits: 11 enable programming, 00 disable programming, 10 erase all, 01 write all. The remaining address bits of an extended command have no effect.
- R2: A read drives a single 0 on `do_bit` at the edge that takes the last address bit. Each following `sk` edge then presents the next bit of the location, MSB first: 16 bits in x16 mode, 8 in x8 mode. In x16 mode, word `a` is made of byte 2a as its high half and byte 2a+1 as its low half.
- R3: A read continues while `cs` stays high. After the last bit of a location, the next edge presents the MSB of the following location. The address wraps from the top location to location 0.
- R4: A write takes 16 (x16) or 8 (x8) data bits after the address, MSB first. Its cycle starts one `clk` after the edge that takes the last data bit, lasts `T_WORD` clocks, and then stores the data.
- R5: An erase starts its `T_WORD` cycle one `clk` after the edge that takes the last address bit. At the end of the cycle the addressed location is all ones.
- R6: Erase-all runs for `T_ERAL` clocks and leaves every location all ones.
- R7: Write-all takes data bits in the same way as a write, runs for `T_WRAL` clocks, and leaves every location equal to that data.
- R8: Once a programming cycle has started and while `cs` is high, `do_oe` is 1. `do_bit` is 0 while the cycle runs and 1 once it has ended. This status stays on until a start bit is received, and `do_oe` then returns to 0.
- R9: With `cs` low and no cycle running, `do_oe` is 0. The pending status or read is dropped, so raising `cs` again leaves `do_oe` at 0.
- R10: While a cycle runs, `sk`, `di` and `cs` transitions have no effect on the command state or on the status. A start bit or a `cs` low pulse sent during the cycle leaves the ready status showing once the cycle ends.
- R11: The write-enable latch is clear after reset and is cleared by the disable command. While it is clear, programming commands change nothing in the array and start no cycle, and `do_oe` stays 0.
- R12: After reset `do_oe` is 0 and every array location reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled in the `clk` domain |
| di | input | 1 | Serial command and data input |
| org_x16 | input | 1 | 1 = 16-bit words, 0 = bytes |
| do_bit | output | 1 | Serial read data or ready/busy status |
| do_oe | output | 1 | Output enable for `do_bit`; 0 means high impedance |

## Verification
The hardest case to reach is traffic that arrives while a self-timed cycle is running. The status must survive a `cs` low pulse and a start bit that would each clear it at any other time. The bench starts a write and then, before the cycle can end, drops `cs` for two clocks and clocks in two start bits. Because `cs` goes high again well before the cycle finishes, ready must appear with the output still enabled, and the array must show only the intended write. Other boundary cases are a read that wraps past the top word, and bytes written in x8 mode and read back as halves of a word in x16 mode.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_HDR, RX_DATA, RX_HOLD} rx_st_e;
  typedef enum logic [2:0] {PG_NONE, PG_WORD_WR, PG_WORD_ER, PG_ALL_ER, PG_ALL_WR} pg_kind_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] OP_EXT   = 2'b00;

  localparam logic [1:0] SUB_EWEN = 2'b11;
  localparam logic [1:0] SUB_EWDS = 2'b00;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_WRAL = 2'b01;

  // bits per location in the selected organisation
  function automatic int unsigned word_bits(input logic x16);
    return x16 ? 16 : 8;
  endfunction

  // address bits per frame in the selected organisation
  function automatic int unsigned addr_bits(input int unsigned aw16, input logic x16);
    return x16 ? aw16 : aw16 + 1;
  endfunction
endpackage

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mw_pkg::*;
#(
  parameter int AW16 = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            abort,
  input  logic            di,
  input  logic            x16,
  output logic            start_seen,
  output logic            hdr_done,
  output logic            data_done,
  output logic [1:0]      op,
  output logic [AW16:0]   addr,
  output logic [15:0]     data
);
  localparam int AWX = AW16 + 1;
  localparam int CW  = $clog2(AWX + 18);

  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic [AW16:0] addr_nx;
  logic [1:0]    sub_nx;
  logic          hdr_last, data_last, want_data;

  assign addr_nx   = {addr[AW16-1:0], di};
  assign sub_nx    = x16 ? addr_nx[AW16-1 -: 2] : addr_nx[AW16 -: 2];
  assign hdr_last  = (st == RX_HDR) && step && (cnt == CW'(addr_bits(AW16, x16) + 1));
  assign data_last = (st == RX_DATA) && step && (cnt == CW'(word_bits(x16) - 1));
  assign want_data = (op == OP_WRITE) || ((op == OP_EXT) && (sub_nx == SUB_WRAL));
  assign start_seen = (st == RX_IDLE) && step && di;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE;
      cnt <= '0;
      op <= '0;
      addr <= '0;
      data <= '0;
      hdr_done <= 1'b0;
      data_done <= 1'b0;
    end else begin
      hdr_done  <= hdr_last;
      data_done <= data_last;
      if (abort) begin
        st <= RX_IDLE;
      end else if (step) begin
        case (st)
          RX_IDLE: if (di) begin
            st <= RX_HDR;
            cnt <= '0;
            op <= '0;
            addr <= '0;
          end
          RX_HDR: begin
            cnt <= cnt + 1'b1;
            if (cnt < CW'(2)) op <= {op[0], di};
            else addr <= addr_nx;
            if (hdr_last) begin
              cnt <= '0;
              st <= (op == OP_READ) ? RX_HOLD : (want_data ? RX_DATA : RX_IDLE);
            end
          end
          RX_DATA: begin
            data <= {data[14:0], di};
            cnt <= cnt + 1'b1;
            if (data_last) st <= RX_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer
  import mw_pkg::*;
#(
  parameter int T_WORD = 120,
  parameter int T_ERAL = 320,
  parameter int T_WRAL = 640
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  pg_kind_e kind_in,
  output logic     busy,
  output logic     fire,
  output logic     wipe,
  output pg_kind_e kind
);
  localparam int TMAX = (T_WRAL > T_ERAL) ? ((T_WRAL > T_WORD) ? T_WRAL : T_WORD)
                                          : ((T_ERAL > T_WORD) ? T_ERAL : T_WORD);
  localparam int CW = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] last_of(input pg_kind_e k);
    case (k)
      PG_ALL_ER: return CW'(T_ERAL - 1);
      PG_ALL_WR: return CW'(T_WRAL - 1);
      default:   return CW'(T_WORD - 1);
    endcase
  endfunction

  assign fire = busy && (cnt == last_of(kind));
  // write-all clears the array at the end of its built-in erase phase
  assign wipe = busy && (kind == PG_ALL_WR) && (cnt == CW'(T_ERAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt <= '0;
      kind <= PG_NONE;
    end else if (start) begin
      busy <= 1'b1;
      cnt <= '0;
      kind <= kind_in;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (fire) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int AW16 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x16,
  input  logic          apply,
  input  logic          wipe,
  input  pg_kind_e      kind,
  input  logic [AW16:0] addr,
  input  logic [15:0]   data,
  input  logic [AW16:0] rd_addr,
  output logic [15:0]   rd_word
);
  localparam int BW = AW16 + 1;
  localparam int NB = 2 ** BW;

  logic [7:0]    bytes_w [NB];
  logic [BW-1:0] rd_hi, rd_lo;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam logic [BW-1:0] G_IDX = BW'(g);
    logic [7:0] q;
    logic       hit;
    logic [7:0] wval;
    assign hit  = x16 ? (addr[AW16-1:0] == G_IDX[BW-1:1]) : (addr == G_IDX);
    assign wval = (x16 && !G_IDX[0]) ? data[15:8] : data[7:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'hFF;
      else if (wipe) q <= 8'hFF;
      else if (apply) begin
        case (kind)
          PG_WORD_WR: if (hit) q <= wval;
          PG_WORD_ER: if (hit) q <= 8'hFF;
          PG_ALL_ER:  q <= 8'hFF;
          PG_ALL_WR:  q <= wval;
          default: ;
        endcase
      end
    end
    assign bytes_w[g] = q;
  end

  assign rd_hi   = {rd_addr[AW16-1:0], 1'b0};
  assign rd_lo   = {rd_addr[AW16-1:0], 1'b1};
  assign rd_word = x16 ? {bytes_w[rd_hi], bytes_w[rd_lo]} : {8'h00, bytes_w[rd_addr]};
endmodule

// File: rtl/mw_eeprom_ctl.sv
module mw_eeprom_ctl
  import mw_pkg::*;
#(
  parameter int AW16   = 6,
  parameter int T_WORD = 120,
  parameter int T_ERAL = 320,
  parameter int T_WRAL = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org_x16,
  output logic do_bit,
  output logic do_oe
);
  logic          sk_q, sk_rise, step, abort;
  logic          start_seen, hdr_done, data_done;
  logic [1:0]    op, sub;
  logic [AW16:0] addr, rd_ptr, ptr_nx;
  logic [15:0]   data, rd_word;
  logic          busy, prog_fire, wipe, wel, show;
  logic          req_valid, prog_start, rd_launch, rd_on, rd_q;
  logic [3:0]    idx;
  pg_kind_e      req_kind, run_kind;

  assign sk_rise = sk & ~sk_q;
  assign step    = sk_rise & cs & ~busy;
  assign abort   = ~cs & ~busy;
  assign sub     = org_x16 ? addr[AW16-1 -: 2] : addr[AW16 -: 2];

  always_comb begin
    req_valid = 1'b0;
    req_kind  = PG_NONE;
    if (hdr_done && op == OP_ERASE) begin
      req_valid = 1'b1; req_kind = PG_WORD_ER;
    end else if (hdr_done && op == OP_EXT && sub == SUB_ERAL) begin
      req_valid = 1'b1; req_kind = PG_ALL_ER;
    end else if (data_done) begin
      req_valid = 1'b1;
      req_kind  = (op == OP_WRITE) ? PG_WORD_WR : PG_ALL_WR;
    end
  end

  assign prog_start = req_valid & wel;
  assign rd_launch  = hdr_done && (op == OP_READ);
  assign ptr_nx     = org_x16 ? {1'b0, rd_ptr[AW16-1:0] + 1'b1} : rd_ptr + 1'b1;

  mw_frame_rx #(.AW16(AW16)) u_rx (
    .clk(clk), .rst_n(rst_n), .step(step), .abort(abort), .di(di), .x16(org_x16),
    .start_seen(start_seen), .hdr_done(hdr_done), .data_done(data_done),
    .op(op), .addr(addr), .data(data)
  );

  mw_prog_timer #(.T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .kind_in(req_kind),
    .busy(busy), .fire(prog_fire), .wipe(wipe), .kind(run_kind)
  );

  mw_array #(.AW16(AW16)) u_mem (
    .clk(clk), .rst_n(rst_n), .x16(org_x16), .apply(prog_fire), .wipe(wipe),
    .kind(run_kind), .addr(addr), .data(data), .rd_addr(rd_ptr), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      wel <= 1'b0;
      show <= 1'b0;
    end else begin
      sk_q <= sk;
      if (hdr_done && op == OP_EXT && sub == SUB_EWEN) wel <= 1'b1;
      else if (hdr_done && op == OP_EXT && sub == SUB_EWDS) wel <= 1'b0;
      if (prog_start) show <= 1'b1;
      else if (abort || start_seen) show <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_on <= 1'b0;
      rd_q <= 1'b0;
      rd_ptr <= '0;
      idx <= '0;
    end else if (abort) begin
      rd_on <= 1'b0;
    end else if (rd_launch) begin
      rd_on <= 1'b1;
      rd_q <= 1'b0;
      rd_ptr <= addr;
      idx <= 4'(word_bits(org_x16) - 1);
    end else if (rd_on && step) begin
      rd_q <= rd_word[idx];
      if (idx == 4'd0) begin
        idx <= 4'(word_bits(org_x16) - 1);
        rd_ptr <= ptr_nx;
      end else begin
        idx <= idx - 1'b1;
      end
    end
  end

  assign do_oe  = cs & (show | rd_on);
  assign do_bit = show ? ~busy : rd_q;
endmodule

// File: rtl/mw_eeprom_ctl_chk.sv
module mw_eeprom_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic do_bit,
  input logic do_oe,
  input logic busy,
  input logic wel,
  input logic step,
  input logic prog_start,
  input logic prog_fire,
  input logic rd_launch,
  input logic start_seen
);
  a_r11_launch_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wel);
  a_r2_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_launch |=> !do_bit);
  a_r10_no_step_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !step);
  a_r8_busy_shows_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_oe) |-> !do_bit);
  a_r4_cycle_ends: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |=> !busy);
  a_r8_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !do_oe);
endmodule

bind mw_eeprom_ctl mw_eeprom_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .do_bit(do_bit), .do_oe(do_oe), .busy(busy), .wel(wel),
  .step(step), .prog_start(prog_start), .prog_fire(prog_fire), .rd_launch(rd_launch),
  .start_seen(start_seen)
);

// File: tb/mw_eeprom_ctl_bench.sv
module mw_eeprom_ctl_bench;
  localparam int AW16 = 6;
  localparam int TW = 120, TE = 320, TA = 640;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_bit, do_oe;
  int n_run = 0, n_fail = 0;
  bit fin = 0;
  logic [7:0] mm [128];
  bit wel_m = 0;

  mw_eeprom_ctl #(.AW16(AW16), .T_WORD(TW), .T_ERAL(TE), .T_WRAL(TA)) u_mw_eeprom_ctl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org_x16(org),
    .do_bit(do_bit), .do_oe(do_oe)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int abits(); return org ? AW16 : AW16 + 1; endfunction
  function automatic int wbits(); return org ? 16 : 8; endfunction
  function automatic int depth(); return org ? 64 : 128; endfunction
  function automatic int mword(input int a);
    return org ? {mm[2*a], mm[2*a+1]} : int'(mm[a]);
  endfunction

  task automatic sk_bit(input logic b);
    @(negedge clk); di = b; sk = 1'b1;
    @(negedge clk); @(negedge clk); sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_on();  @(negedge clk); cs = 1'b1; @(negedge clk); endtask
  task automatic cs_off(); @(negedge clk); cs = 1'b0; @(negedge clk); @(negedge clk); endtask

  task automatic send_hdr(input logic [1:0] op, input int a);
    sk_bit(1'b1); sk_bit(op[1]); sk_bit(op[0]);
    for (int i = abits() - 1; i >= 0; i--) sk_bit(1'((a >> i) & 1));
  endtask

  task automatic send_data(input int d);
    for (int i = wbits() - 1; i >= 0; i--) sk_bit(1'((d >> i) & 1));
  endtask

  task automatic wait_ready(input string req, input int t);
    int cnt = 0;
    check({req, " busy shown"}, {31'd0, do_oe & ~do_bit}, 1);
    while (do_oe && !do_bit && cnt < 5000) begin @(negedge clk); cnt++; end
    check({req, " cycle length"}, cnt, t - 1);
    check({req, " ready shown"}, {30'd0, do_oe, do_bit}, 3);
  endtask

  task automatic read_seq(input string req, input int a, input int n);
    cs_on();
    send_hdr(2'b10, a);
    check({req, " dummy bit"}, {30'd0, do_oe, do_bit}, 2);
    for (int k = 0; k < n; k++) begin
      int got = 0;
      int aa = (a + k) % depth();
      for (int b = 0; b < wbits(); b++) begin sk_bit(1'b0); got = (got << 1) | int'(do_bit); end
      check(req, got, mword(aa));
    end
    cs_off();
  endtask

  task automatic model_store(input int a, input int d);
    if (org) begin mm[2*a] = 8'(d >> 8); mm[2*a+1] = 8'(d); end
    else mm[a] = 8'(d);
  endtask

  task automatic do_write(input string req, input int a, input int d);
    cs_on(); send_hdr(2'b01, a); send_data(d);
    if (wel_m) begin wait_ready(req, TW); model_store(a, d); end
    else begin repeat (4) @(negedge clk); check({req, " ignored, no output"}, {31'd0, do_oe}, 0); end
    cs_off();
  endtask

  task automatic do_erase(input string req, input int a);
    cs_on(); send_hdr(2'b11, a);
    if (wel_m) begin wait_ready(req, TW); model_store(a, org ? 16'hFFFF : 8'hFF); end
    else begin repeat (4) @(negedge clk); check({req, " ignored, no output"}, {31'd0, do_oe}, 0); end
    cs_off();
  endtask

  task automatic do_ext(input logic [1:0] sub);
    cs_on(); send_hdr(2'b00, int'(sub) << (abits() - 2)); cs_off();
    if (sub == 2'b11) wel_m = 1;
    if (sub == 2'b00) wel_m = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 output disabled after reset", {31'd0, do_oe}, 0);
    read_seq("R12 erased after reset", 0, 2);

    do_write("R11 write while latch clear", 5, 16'hA5C3);
    read_seq("R11 array unchanged", 5, 1);

    do_ext(2'b11);
    do_write("R4 write", 5, 16'hA5C3);
    read_seq("R2 read word", 5, 1);
    do_write("R4 write", 6, 16'h1234);
    read_seq("R3 sequential", 5, 3);
    do_write("R4 write top", 63, 16'hBEEF);
    read_seq("R3 wrap", 63, 2);

    do_erase("R5 erase", 5);
    read_seq("R5 erased word", 4, 3);

    // R10: traffic during a running cycle
    cs_on(); send_hdr(2'b01, 9); send_data(16'h0F0F);
    @(negedge clk); cs = 1'b0; @(negedge clk); @(negedge clk); cs = 1'b1;
    sk_bit(1'b1); sk_bit(1'b1);
    begin
      int g = 0;
      while (!do_bit && g < 5000) begin @(negedge clk); g++; end
    end
    model_store(9, 16'h0F0F);
    check("R10 status kept through busy traffic", {30'd0, do_oe, do_bit}, 3);
    sk_bit(1'b0);
    check("R1 leading zero ignored", {30'd0, do_oe, do_bit}, 3);
    sk_bit(1'b1);
    check("R8 start bit releases output", {31'd0, do_oe}, 0);
    cs_off();
    read_seq("R10 only intended write", 8, 3);

    cs_on(); send_hdr(2'b11, 6); wait_ready("R9 erase", TW); model_store(6, 16'hFFFF);
    cs_off();
    check("R9 standby disables output", {31'd0, do_oe}, 0);
    cs_on();
    check("R9 status dropped after standby", {31'd0, do_oe}, 0);
    cs_off();

    do_ext(2'b00);
    do_erase("R11 erase after disable", 9);
    read_seq("R11 disabled erase kept data", 9, 1);

    do_ext(2'b11);
    cs_on(); send_hdr(2'b00, (2 << (abits() - 2)) | 5); wait_ready("R6 erase all", TE); cs_off();
    for (int i = 0; i < 128; i++) mm[i] = 8'hFF;
    read_seq("R6 all ones", 62, 4);

    cs_on(); send_hdr(2'b00, (1 << (abits() - 2)) | 3); send_data(16'h5A3C);
    wait_ready("R7 write all", TA); cs_off();
    for (int i = 0; i < 64; i++) model_store(i, 16'h5A3C);
    read_seq("R7 all written", 30, 3);

    org = 1'b0;
    read_seq("R2 x8 byte order", 2, 3);
    do_write("R1 x8 write", 65, 8'h7E);
    read_seq("R1 x8 readback", 64, 2);
    org = 1'b1;
    read_seq("R2 x16 view of x8 byte", 32, 1);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule